// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block lets an external host read and write a bank of 8-bit configuration registers over a four-pin serial control port. The port has an active-low select, a serial clock, a bidirectional data line (brought to the block as separate input, output and output-enable signals) and a dedicated serial output. Each transfer opens with an 8-bit header that holds a read flag, a byte-count flag and a 6-bit register address. One data byte follows on a read. One or two data bytes follow on a write.

Register 0 is the mode register, and it sets two run-time options. The first is the bit order: most significant bit first, or the whole header and data reversed. The second is the readback path: the dedicated output in 4-wire mode, or the bidirectional line turned around to drive in 3-wire mode. The serial pins are sampled with a fast system clock, and all state changes happen in that clock domain. A parallel host port gives a direct view of any register so that bank contents can be checked.

Top module: `spi_cfg_slave`

## Requirements
- R1: After reset, all 64 registers read zero, both output enables are low, and the port runs in MSB-first, 4-wire mode.
- R2: The header is sampled on rising serial-clock edges. In MSB-first order, bit 7 is the read flag (1 = read), bit 6 is the byte-count flag, and bits 5..0 are the address. A write stores its data byte only after the 8th data bit has been sampled.
- R3: When mode bit 0 is 1 (LSB-first), the header arrives as address bit 0 first and read flag last, and the data arrives as bit 0 first. This holds for both writes and reads.
- R4: A read returns exactly one byte, even when the byte-count flag is set. Read bits are launched on falling edges, starting with the falling edge that ends the header. The output enable drops on the 9th falling edge.
- R5: When mode bit 1 is 0, read data and its enable appear on the dedicated output. When mode bit 1 is 1, they appear on the bidirectional line instead. The two enables are never high together.
- R6: A write with the byte-count flag set stores a second byte at address+1, modulo 64. A write with the flag clear stores one byte, and any further bits are ignored.
- R7: Raising the select at any point ends the transfer. Both enables are released, a partial data byte is discarded, and the next transfer starts from a clean header.
- R8: A write to the mode register takes effect only from the next transfer. The rest of the current transfer keeps the old bit order.
- R9: The host port returns the register selected by the host address, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sen_n | input | 1 | Active-low transfer select |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_sdio_i | input | 1 | Bidirectional data line, input side |
| spi_sdio_o | output | 1 | Bidirectional data line, output value |
| spi_sdio_oe | output | 1 | Drive enable for the bidirectional line (3-wire read) |
| spi_sdo | output | 1 | Dedicated serial output value |
| spi_sdo_oe | output | 1 | Drive enable for the dedicated output (4-wire read) |
| host_addr | input | 6 | Host-port register select |
| host_rdata | output | 8 | Host-port register contents |

## Verification
The bench builds the block with its defaults: a 6-bit address, 8-bit data and two synchronizer stages. These values put all 64 registers in reach, so the reset check covers the whole bank. Address bit-reversal can then be exposed with an address such as 7, whose reversed form 56 is a distinct register. With 8-bit data, a byte like 0x96 shows whether a mode change mid-transfer altered the bit order, because its reversed form differs. Each bit of the serial clock lasts sixteen system clocks, which leaves room to sample launched read bits before the next rising edge.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

  localparam int unsigned CFG_ADDR_W    = 6;
  localparam int unsigned CFG_DATA_W    = 8;
  localparam int unsigned MODE_REG_ADDR = 0;
  localparam int unsigned MODE_LSB_BIT  = 0;
  localparam int unsigned MODE_3W_BIT   = 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_WDAT,
    ST_RDAT,
    ST_DONE
  } spi_state_e;

endpackage

// File: rtl/spi_cfg_rst_sync.sv
module spi_cfg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync #(
  parameter int unsigned   W       = 1,
  parameter int unsigned   STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= {STAGES{RST_VAL}};
    end else begin
      pipe_q[0] <= d;
      for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/spi_cfg_regbank.sv
module spi_cfg_regbank
  import spi_cfg_pkg::*;
#(
  parameter int unsigned AW = CFG_ADDR_W,
  parameter int unsigned DW = CFG_DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  input  logic [AW-1:0] host_addr_i,
  output logic [DW-1:0] host_rdata_o,
  output logic          mode_lsb_o,
  output logic          mode_3w_o
);

  localparam int unsigned NREG = 1 << AW;

  logic [DW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DW-1:0] q;
    logic          hit;
    assign hit = wr_en_i && (wr_addr_i == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (hit) q <= wr_data_i;
    end
    assign regs[g] = q;
  end

  assign rd_data_o    = regs[rd_addr_i];
  assign host_rdata_o = regs[host_addr_i];
  assign mode_lsb_o   = regs[MODE_REG_ADDR][MODE_LSB_BIT];
  assign mode_3w_o    = regs[MODE_REG_ADDR][MODE_3W_BIT];

endmodule

// File: rtl/spi_cfg_engine.sv
module spi_cfg_engine
  import spi_cfg_pkg::*;
#(
  parameter int unsigned AW = CFG_ADDR_W,
  parameter int unsigned DW = CFG_DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sen_s,
  input  logic          sclk_s,
  input  logic          din_s,
  input  logic          mode_lsb_i,
  input  logic          mode_3w_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [DW-1:0] rd_data_i,
  output logic          sdo_o,
  output logic          sdo_oe_o,
  output logic          sdio_o,
  output logic          sdio_oe_o,
  output logic          rise_o,
  output logic          fall_o,
  output logic          busy_o,
  output logic          cur_lsb_o,
  output logic          cur_3w_o
);

  localparam int unsigned HW    = AW + 2;
  localparam int unsigned MAXB  = (DW > HW) ? DW : HW;
  localparam int unsigned CW    = $clog2(MAXB + 1);
  localparam int unsigned IW    = $clog2(DW);
  localparam logic [CW-1:0] HDR_LAST = CW'(HW - 1);
  localparam logic [CW-1:0] DAT_LAST = CW'(DW - 1);
  localparam logic [CW-1:0] DAT_CNT  = CW'(DW);

  spi_state_e    state_q, state_n;
  logic          sclk_d_q;
  logic [CW-1:0] bcnt_q, bcnt_n;
  logic [HW-1:0] hsh_q, hsh_n, hsh_shift;
  logic [DW-1:0] dsh_q, dsh_n, dsh_shift;
  logic [AW-1:0] addr_q, addr_n;
  logic          two_q, two_n;
  logic          byte2_q, byte2_n;
  logic          lsb_q, lsb_n;
  logic          tw_q, tw_n;
  logic [DW-1:0] txd_q, txd_n;
  logic [CW-1:0] tidx_q, tidx_n;
  logic          dout_q, dout_n;
  logic          oe_q, oe_n;
  logic          rise, fall;

  assign rise = sclk_s & ~sclk_d_q;
  assign fall = ~sclk_s & sclk_d_q;

  assign hsh_shift = lsb_q ? {din_s, hsh_q[HW-1:1]} : {hsh_q[HW-2:0], din_s};
  assign dsh_shift = lsb_q ? {din_s, dsh_q[DW-1:1]} : {dsh_q[DW-2:0], din_s};

  always_comb begin
    state_n   = state_q;
    bcnt_n    = bcnt_q;
    hsh_n     = hsh_q;
    dsh_n     = dsh_q;
    addr_n    = addr_q;
    two_n     = two_q;
    byte2_n   = byte2_q;
    lsb_n     = lsb_q;
    tw_n      = tw_q;
    txd_n     = txd_q;
    tidx_n    = tidx_q;
    dout_n    = dout_q;
    oe_n      = oe_q;
    wr_en_o   = 1'b0;
    wr_addr_o = addr_q;
    wr_data_o = dsh_shift;
    if (sen_s) begin
      state_n = ST_IDLE;
      bcnt_n  = '0;
      byte2_n = 1'b0;
      tidx_n  = '0;
      oe_n    = 1'b0;
      lsb_n   = mode_lsb_i;
      tw_n    = mode_3w_i;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_n = ST_HDR;
          bcnt_n  = '0;
        end
        ST_HDR: if (rise) begin
          hsh_n = hsh_shift;
          if (bcnt_q == HDR_LAST) begin
            bcnt_n = '0;
            addr_n = hsh_shift[AW-1:0];
            two_n  = hsh_shift[AW];
            if (hsh_shift[AW+1]) begin
              state_n = ST_RDAT;
              txd_n   = rd_data_i;
              tidx_n  = '0;
            end else begin
              state_n = ST_WDAT;
            end
          end else begin
            bcnt_n = bcnt_q + 1'b1;
          end
        end
        ST_WDAT: if (rise) begin
          dsh_n = dsh_shift;
          if (bcnt_q == DAT_LAST) begin
            wr_en_o = 1'b1;
            addr_n  = addr_q + 1'b1;
            bcnt_n  = '0;
            if (two_q && !byte2_q) byte2_n = 1'b1;
            else                   state_n = ST_DONE;
          end else begin
            bcnt_n = bcnt_q + 1'b1;
          end
        end
        ST_RDAT: if (fall) begin
          if (tidx_q < DAT_CNT) begin
            dout_n = lsb_q ? txd_q[tidx_q[IW-1:0]]
                           : txd_q[IW'(DW - 1) - tidx_q[IW-1:0]];
            oe_n   = 1'b1;
            tidx_n = tidx_q + 1'b1;
          end else begin
            oe_n    = 1'b0;
            state_n = ST_DONE;
          end
        end
        ST_DONE: oe_n = 1'b0;
        default: state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      sclk_d_q <= 1'b0;
      bcnt_q   <= '0;
      hsh_q    <= '0;
      dsh_q    <= '0;
      addr_q   <= '0;
      two_q    <= 1'b0;
      byte2_q  <= 1'b0;
      lsb_q    <= 1'b0;
      tw_q     <= 1'b0;
      txd_q    <= '0;
      tidx_q   <= '0;
      dout_q   <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      state_q  <= state_n;
      sclk_d_q <= sclk_s;
      bcnt_q   <= bcnt_n;
      hsh_q    <= hsh_n;
      dsh_q    <= dsh_n;
      addr_q   <= addr_n;
      two_q    <= two_n;
      byte2_q  <= byte2_n;
      lsb_q    <= lsb_n;
      tw_q     <= tw_n;
      txd_q    <= txd_n;
      tidx_q   <= tidx_n;
      dout_q   <= dout_n;
      oe_q     <= oe_n;
    end
  end

  assign rd_addr_o = hsh_shift[AW-1:0];
  assign sdo_o     = dout_q;
  assign sdio_o    = dout_q;
  assign sdo_oe_o  = oe_q & ~tw_q;
  assign sdio_oe_o = oe_q & tw_q;
  assign rise_o    = rise;
  assign fall_o    = fall;
  assign busy_o    = (state_q != ST_IDLE);
  assign cur_lsb_o = lsb_q;
  assign cur_3w_o  = tw_q;

endmodule

// File: rtl/spi_cfg_slave.sv
module spi_cfg_slave
  import spi_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W      = CFG_ADDR_W,
  parameter int unsigned DATA_W      = CFG_DATA_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sen_n,
  input  logic              spi_sclk,
  input  logic              spi_sdio_i,
  output logic              spi_sdio_o,
  output logic              spi_sdio_oe,
  output logic              spi_sdo,
  output logic              spi_sdo_oe,
  input  logic [ADDR_W-1:0] host_addr,
  output logic [DATA_W-1:0] host_rdata
);

  logic              rst_n_sync;
  logic              sen_s, sclk_s, din_s;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic              mode_lsb, mode_3w;
  logic              sclk_rise, sclk_fall, eng_busy, cur_lsb, cur_3w;

  spi_cfg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  spi_cfg_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sen (
    .clk(clk), .rst_n(rst_n_sync), .d(spi_sen_n), .q(sen_s)
  );

  spi_cfg_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_sync_dat (
    .clk(clk), .rst_n(rst_n_sync), .d({spi_sclk, spi_sdio_i}), .q({sclk_s, din_s})
  );

  spi_cfg_engine #(.AW(ADDR_W), .DW(DATA_W)) u_eng (
    .clk(clk), .rst_n(rst_n_sync),
    .sen_s(sen_s), .sclk_s(sclk_s), .din_s(din_s),
    .mode_lsb_i(mode_lsb), .mode_3w_i(mode_3w),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .sdo_o(spi_sdo), .sdo_oe_o(spi_sdo_oe),
    .sdio_o(spi_sdio_o), .sdio_oe_o(spi_sdio_oe),
    .rise_o(sclk_rise), .fall_o(sclk_fall), .busy_o(eng_busy),
    .cur_lsb_o(cur_lsb), .cur_3w_o(cur_3w)
  );

  spi_cfg_regbank #(.AW(ADDR_W), .DW(DATA_W)) u_bank (
    .clk(clk), .rst_n(rst_n_sync),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .host_addr_i(host_addr), .host_rdata_o(host_rdata),
    .mode_lsb_o(mode_lsb), .mode_3w_o(mode_3w)
  );

endmodule

// File: rtl/spi_cfg_slave_chk.sv
module spi_cfg_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic sen_s,
  input logic rise,
  input logic fall,
  input logic wr_en,
  input logic busy,
  input logic cur_lsb,
  input logic cur_3w,
  input logic sdo_oe,
  input logic sdio_oe
);

  // R1: drivers stay released while the synchronized reset is held
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (!sdo_oe && !sdio_oe));

  // R2: a register write is only committed on a sampling edge inside a transfer
  p_commit_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (rise && !sen_s));

  // R4: a read driver turns on only right after a falling serial-clock edge
  p_launch_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe || sdio_oe) |-> $past(fall));

  // R5: never both outputs driving
  p_one_driver_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(sdo_oe && sdio_oe));

  // R7: deselect releases both drivers by the next cycle
  p_abort_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sen_s |=> (!sdo_oe && !sdio_oe));

  // R8: the mode in use is frozen for the duration of a transfer
  p_mode_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || ($stable(cur_lsb) && $stable(cur_3w))));

endmodule

bind spi_cfg_slave spi_cfg_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n_sync), .sen_s(sen_s), .rise(sclk_rise),
  .fall(sclk_fall), .wr_en(wr_en), .busy(eng_busy), .cur_lsb(cur_lsb),
  .cur_3w(cur_3w), .sdo_oe(spi_sdo_oe), .sdio_oe(spi_sdio_oe)
);

// File: tb/tb_spi_cfg_slave.sv
module tb_spi_cfg_slave;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;

  logic       clk;
  logic       rst_n;
  logic       spi_sen_n;
  logic       spi_sclk;
  logic       spi_sdio_i;
  logic       spi_sdio_o, spi_sdio_oe, spi_sdo, spi_sdo_oe;
  logic [5:0] host_addr;
  logic [7:0] host_rdata;

  spi_cfg_slave dut (
    .clk(clk), .rst_n(rst_n), .spi_sen_n(spi_sen_n), .spi_sclk(spi_sclk),
    .spi_sdio_i(spi_sdio_i), .spi_sdio_o(spi_sdio_o), .spi_sdio_oe(spi_sdio_oe),
    .spi_sdo(spi_sdo), .spi_sdo_oe(spi_sdo_oe),
    .host_addr(host_addr), .host_rdata(host_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int         n_chk  = 0;
  int         n_fail = 0;
  bit         done   = 0;
  bit         oe_bad;
  logic [7:0] model [64];
  logic [7:0] exp_q [$];
  logic [7:0] act_q [$];
  string      tag_q [$];

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pairs observed read bytes with predicted ones
  always begin
    @(negedge clk);
    while (act_q.size() > 0 && exp_q.size() > 0) begin
      logic [7:0] a, e;
      string      t;
      a = act_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, a, e);
    end
  end

  task automatic send_bit(input logic b);
    spi_sdio_i = b;
    repeat (HALF) @(negedge clk);
    spi_sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    spi_sclk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v, input bit lsb);
    for (int i = 0; i < 8; i++) send_bit(lsb ? v[i] : v[7-i]);
  endtask

  task automatic read_bit(input bit w3, output logic b);
    repeat (HALF) @(negedge clk);
    b = w3 ? spi_sdio_o : spi_sdo;
    if (w3 ? !(spi_sdio_oe && !spi_sdo_oe) : !(spi_sdo_oe && !spi_sdio_oe)) oe_bad = 1;
    spi_sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    spi_sclk = 1'b0;
  endtask

  task automatic begin_xfer();
    @(negedge clk);
    spi_sen_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic end_xfer();
    repeat (HALF) @(negedge clk);
    spi_sen_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic spi_write(input bit two, input logic [5:0] a, input logic [7:0] d0,
                           input logic [7:0] d1, input bit extra);
    bit lsb;
    lsb = model[0][0];
    begin_xfer();
    send_byte({1'b0, two, a}, lsb);
    send_byte(d0, lsb);
    if (two || extra) send_byte(d1, lsb);
    end_xfer();
    model[a] = d0;
    if (two) model[a + 6'd1] = d1;
  endtask

  task automatic spi_read(input bit two, input logic [5:0] a, input string tag);
    bit         lsb, w3;
    logic       b;
    logic [7:0] got;
    lsb = model[0][0];
    w3  = model[0][1];
    exp_q.push_back(model[a]);
    tag_q.push_back(tag);
    begin_xfer();
    send_byte({1'b1, two, a}, lsb);
    oe_bad = 0;
    for (int i = 0; i < 8; i++) begin
      read_bit(w3, b);
      got[lsb ? i : 7 - i] = b;
    end
    act_q.push_back(got);
    check("R5 enable on selected pin only", {7'd0, oe_bad}, 8'd0);
    repeat (HALF) @(negedge clk);
    check("R4 released after one byte", {6'd0, spi_sdo_oe, spi_sdio_oe}, 8'd0);
    end_xfer();
  endtask

  task automatic chk_reg(input logic [5:0] a, input string tag);
    host_addr = a;
    #1;
    check(tag, host_rdata, model[a]);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 8'h00;
    rst_n      = 1'b0;
    spi_sen_n  = 1'b1;
    spi_sclk   = 1'b0;
    spi_sdio_i = 1'b0;
    host_addr  = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 and R9: whole bank zero through the host port, drivers off
    for (int i = 0; i < 64; i++) chk_reg(6'(i), "R1 R9 reset contents");
    check("R1 enables after reset", {6'd0, spi_sdo_oe, spi_sdio_oe}, 8'd0);

    // R2: single-byte MSB-first write
    spi_write(1'b0, 6'd5, 8'hA5, 8'h00, 1'b0);
    chk_reg(6'd5, "R2 single write");
    chk_reg(6'd6, "R2 neighbour untouched");

    // R4 R5: MSB-first 4-wire read
    spi_read(1'b0, 6'd5, "R4 read byte msb 4-wire");

    // R6: two-byte write lands at addr and addr+1
    spi_write(1'b1, 6'd10, 8'h3C, 8'hC3, 1'b0);
    chk_reg(6'd10, "R6 first byte");
    chk_reg(6'd11, "R6 second byte");

    // R6: flag clear, trailing byte ignored
    spi_write(1'b0, 6'd20, 8'h11, 8'h22, 1'b1);
    chk_reg(6'd20, "R6 single with extra");
    chk_reg(6'd21, "R6 extra byte ignored");

    // R4: byte-count flag set on a read still yields one byte
    spi_read(1'b1, 6'd10, "R4 read with count flag");

    // R8: set LSB-first in byte 0; byte 1 of same transfer is still MSB-first
    spi_write(1'b1, 6'd0, 8'h01, 8'h96, 1'b0);
    chk_reg(6'd0, "R8 mode written");
    chk_reg(6'd1, "R8 old order kept in transfer");

    // R3: LSB-first write and read; address 7 reversed would be 56
    spi_write(1'b0, 6'd7, 8'h1E, 8'h00, 1'b0);
    chk_reg(6'd7, "R3 lsb write");
    chk_reg(6'd56, "R3 no reversed address");
    spi_read(1'b0, 6'd7, "R3 lsb read");

    // R5: 3-wire, LSB-first read
    spi_write(1'b0, 6'd0, 8'h03, 8'h00, 1'b0);
    spi_read(1'b0, 6'd10, "R5 3-wire lsb read");

    // R5: 3-wire, MSB-first read
    spi_write(1'b0, 6'd0, 8'h02, 8'h00, 1'b0);
    spi_read(1'b0, 6'd11, "R5 3-wire msb read");

    // back to MSB-first 4-wire
    spi_write(1'b0, 6'd0, 8'h00, 8'h00, 1'b0);

    // R7: abort a write after 5 data bits
    begin_xfer();
    send_byte({1'b0, 1'b0, 6'd20}, 1'b0);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    spi_sen_n = 1'b1;
    repeat (12) @(negedge clk);
    chk_reg(6'd20, "R7 partial write discarded");

    // R7: abort a read part-way through the data
    begin
      logic b;
      begin_xfer();
      send_byte({1'b1, 1'b0, 6'd10}, 1'b0);
      for (int i = 0; i < 3; i++) read_bit(1'b0, b);
      repeat (3) @(negedge clk);
      check("R7 driving before abort", {7'd0, spi_sdo_oe}, 8'd1);
      spi_sen_n = 1'b1;
      repeat (6) @(negedge clk);
      check("R7 released on abort", {6'd0, spi_sdo_oe, spi_sdio_oe}, 8'd0);
      repeat (12) @(negedge clk);
    end

    // R7: clean transfer after aborts
    spi_read(1'b0, 6'd20, "R7 read after abort");

    repeat (10) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule